// File: doc/BRIEF.md
# CD Audio-Format Serial Byte Receiver

This block takes the bit-serial sample stream that a CD signal processor sends out and turns it into a stream of bytes for a sector buffer. The inputs are a bit clock, a word (channel) clock, a data line and an erasure (C2) pointer line. All four are brought into the system clock domain and the bit clock is edge-detected there. Each 16-bit sample is split into its two bytes. Every byte comes out as a single-cycle strobe, together with its data, a C2 error flag, the channel it belongs to and the buffer address to write it to.

At run time a few configuration inputs describe the serial format: which bit-clock edge samples data, which word-clock level means the left channel, how many bit clocks make up one channel slot, whether bits arrive LSB or MSB first, and which byte of a sample is delivered first. A 15-bit write address counter can be loaded by the host. It steps once for every byte delivered. The configuration is meant to be changed only while the receive enable is low.

Top module: `cd_serial_rx`

## Requirements
- R1: After reset, byteValid is low, and the first byte delivered without an address load carries address 0.
- R2: With cfgRiseEdge = 1, data, word clock and C2 are sampled on rising bit-clock edges; with cfgRiseEdge = 0 they are sampled on falling edges. Values present only at the other edge have no effect on the delivered bytes.
- R3: A slot sampled with the word clock low is a left slot when cfgLeftLow = 1. A slot sampled with the word clock high is a left slot when cfgLeftLow = 0. byteLeft = 1 marks bytes of left slots.
- R4: cfgSlotMode sets the bit clocks per slot: 2'b00 gives 16, 2'b01 gives 24, 2'b10 and 2'b11 give 32. Only the last 16 bits of a slot form the sample. Leading bits in longer slots, and their C2 levels, are ignored.
- R5: With cfgLsbFirst = 1, the first captured bit is sample bit 0. With cfgLsbFirst = 0, it is sample bit 15.
- R6: With cfgLowFirst = 1, sample bits 7:0 are delivered before bits 15:8. With cfgLowFirst = 0, the order is reversed.
- R7: A byte's byteC2 is the OR of the C2 line over the eight serial bits that carried that byte.
- R8: A pulse on addrLoad sets the address of the next byte to addrLoadValue. Each delivered byte carries the current address, and the address then increases by one.
- R9: The address wraps from 15'h7FFF to 15'h0000.
- R10: No bytes are delivered while rxEnable is low. After rxEnable rises, no bytes come until a change of the sampled word clock has been seen, so a slot whose start was not observed is dropped.
- R11: Each complete slot produces exactly two byte strobes, on consecutive cycles, with the same byteLeft.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receive enable; configuration may change only while low |
| cfgRiseEdge | input | 1 | 1: sample on rising bit-clock edge, 0: falling |
| cfgLeftLow | input | 1 | 1: word clock low marks left, 0: high marks left |
| cfgSlotMode | input | 2 | Bit clocks per slot: 00=16, 01=24, 1x=32 |
| cfgLsbFirst | input | 1 | 1: LSB first, 0: MSB first |
| cfgLowFirst | input | 1 | 1: lower byte delivered first, 0: upper byte first |
| bclkIn | input | 1 | Serial bit clock (asynchronous) |
| lrckIn | input | 1 | Word / channel clock (asynchronous) |
| dataIn | input | 1 | Serial sample data (asynchronous) |
| c2In | input | 1 | C2 erasure pointer (asynchronous) |
| addrLoad | input | 1 | Load pulse for the address counter |
| addrLoadValue | input | 15 | Value loaded into the address counter |
| byteValid | output | 1 | One-cycle strobe for a delivered byte |
| byteData | output | 8 | Delivered byte |
| byteC2 | output | 1 | C2 flag of the delivered byte |
| byteLeft | output | 1 | Byte belongs to a left-channel slot |
| byteAddr | output | 15 | Buffer address for the delivered byte |

## Verification
The checker assumes that the bit clock runs at no more than a quarter of the system clock rate, so the two strobes of one sample always finish before the next sample can complete. It also assumes that addrLoad is never pulsed in the same cycle as a byte strobe, so each address it sees comes either from the last load or from the previous byte plus one. The stimulus holds each bit-clock phase for four system cycles. It changes the configuration and loads the address only while receive is disabled and the line is idle. It also turns the data and C2 lines to their complement halfway through the non-sampling phase, so sampling on the wrong edge gives wrong bytes.

// File: rtl/cdrx_pkg.sv
package cdrx_pkg;
  localparam int SAMPLE_BITS = 16;
  localparam int BYTE_BITS   = 8;
  localparam int MAX_SLOT    = 32;
  localparam int CNT_W       = $clog2(MAX_SLOT) + 1;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;    // capture the sampled data bit
    logic firstBit;   // first bit of the 16-bit capture window
    logic firstHalf;  // bit belongs to the first eight captured
    logic latchWord;  // capture window complete, move word to holding
    logic emitFirst;  // deliver the first byte of the held word
    logic emitSecond; // deliver the second byte of the held word
  } rxCtrlT;
endpackage

// File: rtl/cdrx_ctrl.sv
module cdrx_ctrl
  import cdrx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       cfgRiseEdge,
  input  logic [1:0] cfgSlotMode,
  input  logic       bclkS,
  input  logic       lrckS,
  output rxCtrlT     ctrl,
  output logic       slotLevel
);
  logic             bclkPrev;
  logic             haveLr;
  logic             synced;
  logic [CNT_W-1:0] bitIdx;
  logic             latchQ;
  logic             emitA;
  logic             emitB;

  logic             strobe;
  logic             newSlot;
  logic [CNT_W-1:0] idxNow;
  logic [CNT_W-1:0] slotBits;
  logic [CNT_W-1:0] winStart;
  logic [CNT_W-1:0] pos;
  logic             inWin;
  logic             lastBit;

  always_comb begin
    unique case (cfgSlotMode)
      2'b00:   slotBits = CNT_W'(16);
      2'b01:   slotBits = CNT_W'(24);
      default: slotBits = CNT_W'(32);
    endcase
    winStart = slotBits - CNT_W'(SAMPLE_BITS);
    strobe   = rxEnable && (cfgRiseEdge ? (bclkS && !bclkPrev) : (!bclkS && bclkPrev));
    newSlot  = haveLr && (lrckS != slotLevel);
    idxNow   = newSlot ? '0 : bitIdx;
    inWin    = (synced || newSlot) && (idxNow >= winStart) && (idxNow < slotBits);
    pos      = idxNow - winStart;
    lastBit  = (idxNow == slotBits - CNT_W'(1));

    ctrl.shiftEn    = strobe && inWin;
    ctrl.firstBit   = (pos == '0);
    ctrl.firstHalf  = (pos < CNT_W'(BYTE_BITS));
    ctrl.latchWord  = latchQ;
    ctrl.emitFirst  = emitA;
    ctrl.emitSecond = emitB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkPrev  <= 1'b0;
      haveLr    <= 1'b0;
      synced    <= 1'b0;
      slotLevel <= 1'b0;
      bitIdx    <= '0;
      latchQ    <= 1'b0;
      emitA     <= 1'b0;
      emitB     <= 1'b0;
    end else begin
      bclkPrev <= bclkS;
      emitA    <= latchQ;
      emitB    <= emitA;
      if (!rxEnable) begin
        haveLr <= 1'b0;
        synced <= 1'b0;
        bitIdx <= '0;
        latchQ <= 1'b0;
      end else begin
        latchQ <= strobe && inWin && lastBit;
        if (strobe) begin
          haveLr    <= 1'b1;
          slotLevel <= lrckS;
          if (newSlot) synced <= 1'b1;
          bitIdx <= (idxNow == '1) ? idxNow : idxNow + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cdrx_datapath.sv
module cdrx_datapath
  import cdrx_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxCtrlT               ctrl,
  input  logic                 dataBit,
  input  logic                 c2Bit,
  input  logic                 slotLevel,
  input  logic                 cfgLeftLow,
  input  logic                 cfgLsbFirst,
  input  logic                 cfgLowFirst,
  input  logic                 addrLoad,
  input  logic [ADDR_W-1:0]    addrLoadValue,
  output logic                 byteValid,
  output logic [BYTE_BITS-1:0] byteData,
  output logic                 byteC2,
  output logic                 byteLeft,
  output logic [ADDR_W-1:0]    byteAddr
);
  logic [SAMPLE_BITS-1:0] shiftReg;
  logic                   c2First;
  logic                   c2Second;
  logic [SAMPLE_BITS-1:0] heldWord;
  logic                   heldC2Up;
  logic                   heldC2Lo;
  logic                   heldLeft;
  logic [ADDR_W-1:0]      addrCnt;
  logic                   emitNow;
  logic                   sendLower;

  assign emitNow   = ctrl.emitFirst || ctrl.emitSecond;
  assign sendLower = ctrl.emitFirst ? cfgLowFirst : !cfgLowFirst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      c2First  <= 1'b0;
      c2Second <= 1'b0;
    end else if (ctrl.shiftEn) begin
      shiftReg <= cfgLsbFirst ? {dataBit, shiftReg[SAMPLE_BITS-1:1]}
                              : {shiftReg[SAMPLE_BITS-2:0], dataBit};
      if (ctrl.firstBit) begin
        c2First  <= c2Bit;
        c2Second <= 1'b0;
      end else if (ctrl.firstHalf) begin
        c2First  <= c2First | c2Bit;
      end else begin
        c2Second <= c2Second | c2Bit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldWord <= '0;
      heldC2Up <= 1'b0;
      heldC2Lo <= 1'b0;
      heldLeft <= 1'b0;
    end else if (ctrl.latchWord) begin
      heldWord <= shiftReg;
      heldC2Up <= cfgLsbFirst ? c2Second : c2First;
      heldC2Lo <= cfgLsbFirst ? c2First  : c2Second;
      heldLeft <= slotLevel ^ cfgLeftLow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteValid <= 1'b0;
      byteData  <= '0;
      byteC2    <= 1'b0;
      byteLeft  <= 1'b0;
      byteAddr  <= '0;
      addrCnt   <= '0;
    end else begin
      byteValid <= emitNow;
      if (emitNow) begin
        byteData <= sendLower ? heldWord[BYTE_BITS-1:0] : heldWord[SAMPLE_BITS-1:BYTE_BITS];
        byteC2   <= sendLower ? heldC2Lo : heldC2Up;
        byteLeft <= heldLeft;
        byteAddr <= addrCnt;
      end
      if (addrLoad)     addrCnt <= addrLoadValue;
      else if (emitNow) addrCnt <= addrCnt + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/cd_serial_rx.sv
module cd_serial_rx
  import cdrx_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxEnable,
  input  logic                 cfgRiseEdge,
  input  logic                 cfgLeftLow,
  input  logic [1:0]           cfgSlotMode,
  input  logic                 cfgLsbFirst,
  input  logic                 cfgLowFirst,
  input  logic                 bclkIn,
  input  logic                 lrckIn,
  input  logic                 dataIn,
  input  logic                 c2In,
  input  logic                 addrLoad,
  input  logic [ADDR_W-1:0]    addrLoadValue,
  output logic                 byteValid,
  output logic [BYTE_BITS-1:0] byteData,
  output logic                 byteC2,
  output logic                 byteLeft,
  output logic [ADDR_W-1:0]    byteAddr
);
  localparam int LINES = 4;

  logic [LINES-1:0] rawLines;
  logic [LINES-1:0] syncLines;
  rxCtrlT           ctrl;
  logic             slotLevel;

  assign rawLines = {bclkIn, lrckIn, dataIn, c2In};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    logic [LINES-1:0] q;
    if (s == 0) begin : g_head
      always_ff @(posedge clk) q <= rstN ? rawLines : '0;
    end else begin : g_tail
      always_ff @(posedge clk) q <= rstN ? g_sync[s-1].q : '0;
    end
  end
  assign syncLines = g_sync[SYNC_STAGES-1].q;

  cdrx_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .rxEnable    (rxEnable),
    .cfgRiseEdge (cfgRiseEdge),
    .cfgSlotMode (cfgSlotMode),
    .bclkS       (syncLines[3]),
    .lrckS       (syncLines[2]),
    .ctrl        (ctrl),
    .slotLevel   (slotLevel)
  );

  cdrx_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .dataBit       (syncLines[1]),
    .c2Bit         (syncLines[0]),
    .slotLevel     (slotLevel),
    .cfgLeftLow    (cfgLeftLow),
    .cfgLsbFirst   (cfgLsbFirst),
    .cfgLowFirst   (cfgLowFirst),
    .addrLoad      (addrLoad),
    .addrLoadValue (addrLoadValue),
    .byteValid     (byteValid),
    .byteData      (byteData),
    .byteC2        (byteC2),
    .byteLeft      (byteLeft),
    .byteAddr      (byteAddr)
  );
endmodule

// File: rtl/cdrx_checker.sv
module cdrx_checker #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrLoad,
  input logic [ADDR_W-1:0] addrLoadValue,
  input logic              byteValid,
  input logic              byteLeft,
  input logic [ADDR_W-1:0] byteAddr
);
  logic              phase;     // 1 after the first byte of a pair
  logic              haveLast;
  logic              loadPend;
  logic [ADDR_W-1:0] lastAddr;
  logic [ADDR_W-1:0] loadVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= 1'b0;
      haveLast <= 1'b0;
      loadPend <= 1'b0;
      lastAddr <= '0;
      loadVal  <= '0;
    end else begin
      if (byteValid) begin
        phase    <= ~phase;
        haveLast <= 1'b1;
        lastAddr <= byteAddr;
        loadPend <= 1'b0;
      end
      if (addrLoad) begin
        loadPend <= 1'b1;
        loadVal  <= addrLoadValue;
      end
    end
  end

  // R1: no byte strobe in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> !byteValid);

  // R11: first byte of a pair is followed by the second
  a_r11_pair_follows: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !phase) |=> byteValid);

  // R11: no third strobe after a pair
  a_r11_pair_ends: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && phase) |=> !byteValid);

  // R11: both bytes of a pair share the channel
  a_r11_same_channel: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && phase) |-> (byteLeft == $past(byteLeft)));

  // R8 / R9: consecutive bytes step the address by one, wrapping
  a_r8_step: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && haveLast && !loadPend) |-> (byteAddr == lastAddr + ADDR_W'(1)));

  // R8: first byte after a load uses the loaded address
  a_r8_load: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && loadPend) |-> (byteAddr == loadVal));
endmodule

bind cd_serial_rx cdrx_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .addrLoad      (addrLoad),
  .addrLoadValue (addrLoadValue),
  .byteValid     (byteValid),
  .byteLeft      (byteLeft),
  .byteAddr      (byteAddr)
);

// File: tb/cd_serial_rx_test.sv
module cd_serial_rx_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxEnable = 1'b0;
  logic        cfgRiseEdge = 1'b1;
  logic        cfgLeftLow = 1'b0;
  logic [1:0]  cfgSlotMode = 2'b00;
  logic        cfgLsbFirst = 1'b0;
  logic        cfgLowFirst = 1'b0;
  logic        bclkIn = 1'b0;
  logic        lrckIn = 1'b0;
  logic        dataIn = 1'b0;
  logic        c2In = 1'b0;
  logic        addrLoad = 1'b0;
  logic [14:0] addrLoadValue = '0;
  logic        byteValid;
  logic [7:0]  byteData;
  logic        byteC2;
  logic        byteLeft;
  logic [14:0] byteAddr;

  always #10 clk = ~clk;  // 50 MHz

  cd_serial_rx uut (.*);

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int gotCnt = 0;
  logic [7:0]  gData [16];
  logic        gC2   [16];
  logic        gLeft [16];
  logic [14:0] gAddr [16];

  // {rise, leftLow, mode[1:0], lsbFirst, lowFirst, value[15:0], c2Upper, c2Lower}
  localparam int NVEC = 8;
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 16'hA5C3, 1'b1, 1'b0},
    {1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 16'h1234, 1'b0, 1'b1},
    {1'b1, 1'b1, 2'b01, 1'b0, 1'b1, 16'h8001, 1'b1, 1'b1},
    {1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 16'h5AF0, 1'b0, 1'b0},
    {1'b1, 1'b0, 2'b11, 1'b1, 1'b1, 16'hC0DE, 1'b1, 1'b0},
    {1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 16'h7E81, 1'b0, 1'b1},
    {1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0},
    {1'b0, 1'b1, 2'b00, 1'b1, 1'b1, 16'h0F0F, 1'b1, 1'b0}
  };

  always @(negedge clk) begin
    if (rstN && byteValid && gotCnt < 16) begin
      gData[gotCnt] = byteData;
      gC2[gotCnt]   = byteC2;
      gLeft[gotCnt] = byteLeft;
      gAddr[gotCnt] = byteAddr;
      gotCnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int slotLen(input logic [1:0] m);
    return (m == 2'b00) ? 16 : (m == 2'b01) ? 24 : 32;
  endfunction

  // data and C2 turn to garbage halfway through the non-sampling phase (R2)
  task automatic bitOut(input logic d, input logic lr, input logic c);
    dataIn = d; lrckIn = lr; c2In = c;
    repeat (4) @(negedge clk);
    bclkIn = ~bclkIn;
    repeat (2) @(negedge clk);
    dataIn = ~d; c2In = ~c;
    repeat (2) @(negedge clk);
    bclkIn = ~bclkIn;
  endtask

  task automatic sendSlot(input logic lr, input int w, input logic [15:0] v,
                          input logic cu, input logic cl);
    for (int i = 0; i < w - 16; i++) bitOut(1'b1, lr, 1'b1);
    for (int k = 0; k < 16; k++) begin
      int b;
      b = cfgLsbFirst ? k : 15 - k;
      bitOut(v[b], lr, (b >= 8) ? cu : cl);
    end
  endtask

  task automatic configure(input logic r, input logic ll, input logic [1:0] m,
                           input logic lsb, input logic lf);
    rxEnable = 1'b0;
    repeat (2) @(negedge clk);
    cfgRiseEdge = r; cfgLeftLow = ll; cfgSlotMode = m;
    cfgLsbFirst = lsb; cfgLowFirst = lf;
    bclkIn = r ? 1'b0 : 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic loadAddr(input logic [14:0] v);
    addrLoad = 1'b1; addrLoadValue = v;
    @(negedge clk);
    addrLoad = 1'b0;
  endtask

  // dummy right slot, then a left word v and a right word ~v
  task automatic runPair(input logic [15:0] v, input logic cu, input logic cl);
    logic leftLvl;
    int w;
    leftLvl = ~cfgLeftLow;
    w = slotLen(cfgSlotMode);
    rxEnable = 1'b1;
    gotCnt = 0;
    sendSlot(~leftLvl, w, 16'h3C3C, 1'b1, 1'b1);
    sendSlot(leftLvl, w, v, cu, cl);
    sendSlot(~leftLvl, w, ~v, cl, cu);
    repeat (12) @(negedge clk);
  endtask

  task automatic checkPair(input string tag, input logic [15:0] v, input logic cu,
                           input logic cl, input logic [14:0] base);
    logic [15:0] w2;
    w2 = ~v;
    chk({tag, " R11 byte count"}, gotCnt, 4);
    if (gotCnt == 4) begin
      chk({tag, " R2 R4 R5 R6 byte0"}, gData[0], cfgLowFirst ? v[7:0] : v[15:8]);
      chk({tag, " R2 R4 R5 R6 byte1"}, gData[1], cfgLowFirst ? v[15:8] : v[7:0]);
      chk({tag, " R2 R4 R5 R6 byte2"}, gData[2], cfgLowFirst ? w2[7:0] : w2[15:8]);
      chk({tag, " R2 R4 R5 R6 byte3"}, gData[3], cfgLowFirst ? w2[15:8] : w2[7:0]);
      chk({tag, " R7 c2 byte0"}, gC2[0], cfgLowFirst ? cl : cu);
      chk({tag, " R7 c2 byte1"}, gC2[1], cfgLowFirst ? cu : cl);
      chk({tag, " R7 c2 byte2"}, gC2[2], cfgLowFirst ? cu : cl);
      chk({tag, " R7 c2 byte3"}, gC2[3], cfgLowFirst ? cl : cu);
      chk({tag, " R3 left flags"}, {gLeft[0], gLeft[1], gLeft[2], gLeft[3]}, 4'b1100);
      for (int j = 0; j < 4; j++)
        chk({tag, " R8 R9 address"}, gAddr[j], 15'(base + 15'(j)));
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 byteValid in reset", byteValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 byteValid after reset", byteValid, 0);

    // R1: first pair without any load starts at address 0
    configure(1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
    runPair(16'hBEEF, 1'b0, 1'b1);
    checkPair("reset", 16'hBEEF, 1'b0, 1'b1, 15'h0000);

    // table-driven formats
    for (int i = 0; i < NVEC; i++) begin
      logic [23:0] e;
      logic [14:0] base;
      e = VEC[i];
      configure(e[23], e[22], e[21:20], e[19], e[18]);
      base = 15'(i * 15'h0400 + 15'h0010);
      loadAddr(base);
      runPair(e[17:2], e[1], e[0]);
      checkPair($sformatf("vec%0d", i), e[17:2], e[1], e[0], base);
    end

    // R9: address wrap
    configure(1'b0, 1'b0, 2'b01, 1'b0, 1'b1);
    loadAddr(15'h7FFE);
    runPair(16'h6D2B, 1'b1, 1'b0);
    checkPair("wrap", 16'h6D2B, 1'b1, 1'b0, 15'h7FFE);

    // R10: single slot with no observed word-clock change yields nothing
    configure(1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
    rxEnable = 1'b1;
    gotCnt = 0;
    sendSlot(1'b1, 16, 16'h1111, 1'b0, 1'b0);
    repeat (12) @(negedge clk);
    chk("R10 unsynced slot dropped", gotCnt, 0);

    // R10: alternating slots while disabled yield nothing
    configure(1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
    gotCnt = 0;
    sendSlot(1'b0, 16, 16'h2222, 1'b0, 1'b0);
    sendSlot(1'b1, 16, 16'h3333, 1'b0, 1'b0);
    sendSlot(1'b0, 16, 16'h4444, 1'b0, 1'b0);
    repeat (12) @(negedge clk);
    chk("R10 disabled no bytes", gotCnt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule